// File: doc/BRIEF.md
# Half-Duplex DMA Memory Bridge

This block lets a local controller reach a host computer's main memory as if it were an attached RAM, without stalling while the host is slow. The controller presents an address, a direction bit and, for a write, a data word, and pulses a start strobe. The bridge latches the command and raises a request towards the host. It holds that request with a steady address, direction and data until the host acknowledges it, however many cycles that takes. The host side is modelled as a request/acknowledge port serviced by hardware, with no host program involved.

After the acknowledge the bridge drops its request and, one cycle later, raises a done flag that the controller can poll. On a read, the host's data word is captured into a holding register on the acknowledge cycle, so it is valid by the time done is seen. Only one transfer is outstanding at a time, and each transfer moves data in one direction only. A start strobe that arrives while a transfer is pending is ignored. The busy output is high for the whole time a transfer is pending.

Top module: `hdx_dma_bridge`

## Requirements
- R1: After reset, busy, done and host_req are 0.
- R2: A start strobe sampled while busy is 0 loads the command: from the next cycle on, host_req is 1, busy is 1, and host_addr, host_we and host_wdata equal the values presented with the strobe.
- R3: While host_req is 1 and host_ack is 0, host_req, host_addr, host_we and host_wdata keep their values at the next cycle, for any number of wait cycles.
- R4: On the cycle where host_req and host_ack are both 1 during a read (host_we = 0), host_rdata is captured, and rdata shows it from the next cycle. At all other times rdata keeps its value, including across write transfers.
- R5: In the cycle after the acknowledge, host_req is 0 and busy stays 1. One cycle after that, done is 1 and busy is 0.
- R6: done stays 1 until the next accepted start strobe and is 0 from the cycle after that strobe. busy and done are never 1 together.
- R7: A start strobe sampled while busy is 1 is ignored: the pending command is unchanged and no extra transfer is issued.
- R8: The channel is half-duplex. host_we is 1 for a write (wr_en = 1 at start) and 0 for a read, and stays fixed for the whole transfer.
- R9: host_ack sampled while host_req is 0 has no effect: no request, no done change, no rdata change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle command strobe from the local controller |
| wr_en | input | 1 | Direction with start: 1 = write to host, 0 = read from host |
| addr | input | AW | Host memory address presented with start |
| wdata | input | DW | Write data presented with start |
| busy | output | 1 | A transfer is pending |
| done | output | 1 | The last transfer has completed; polled by the controller |
| rdata | output | DW | Data returned by the last read |
| host_req | output | 1 | Request to the host memory channel |
| host_we | output | 1 | Direction of the request: 1 = write |
| host_addr | output | AW | Address of the request |
| host_wdata | output | DW | Data of a write request |
| host_ack | input | 1 | Host has serviced the request (valid with host_rdata) |
| host_rdata | input | DW | Host data for a read, sampled with host_ack |

## Verification
Transfers are driven with a host model that acknowledges after a chosen wait of zero to many cycles. Zero-wait acknowledges show the request is taken in its first cycle, and long waits show the command is held still. Random mixes of reads and writes to a small address window are run against a reference memory. A read that follows a write to the same address shows that the write data reached the host and that the read data was captured, while a later write shows rdata is left alone. Start strobes injected during pending transfers, and acknowledges given while idle, show that inputs outside the handshake leave the command, done and rdata untouched.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_FIN  = 2'd2
    } hdx_state_e;

    typedef struct packed {
        hdx_state_e st;
        logic       done;
    } hdx_ctrl_t;

endpackage

// File: rtl/hdx_ctrl.sv
module hdx_ctrl
    import hdx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic host_ack,
    output logic load,
    output logic cap_en,
    output logic req,
    output logic busy,
    output logic done
);

    hdx_ctrl_t c_d, c_q;

    always_comb begin
        c_d    = c_q;
        load   = 1'b0;
        cap_en = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    load     = 1'b1;
                    c_d.done = 1'b0;
                    c_d.st   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (host_ack) begin
                    cap_en = 1'b1;
                    c_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                c_d.done = 1'b1;
                c_d.st   = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st   <= ST_IDLE;
            c_q.done <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign req  = (c_q.st == ST_WAIT);
    assign busy = (c_q.st != ST_IDLE);
    assign done = c_q.done;

    // R7: a strobe during a pending transfer never loads a new command
    a_r7_no_load_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |-> !load);

    // R6: busy and done are exclusive
    a_r6_busy_excl_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R6: done is cleared by an accepted strobe
    a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done && busy);

endmodule

// File: rtl/hdx_cmd_regs.sv
module hdx_cmd_regs #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          cmd_we,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_wdata
);

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d = cmd_q;
        if (load) begin
            cmd_d.we    = wr_en;
            cmd_d.addr  = addr;
            cmd_d.wdata = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign cmd_we    = cmd_q.we;
    assign cmd_addr  = cmd_q.addr;
    assign cmd_wdata = cmd_q.wdata;

    // R3: command stays put without a load
    a_r3_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cmd_addr) && $stable(cmd_we) && $stable(cmd_wdata));

endmodule

// File: rtl/hdx_rd_hold.sv
module hdx_rd_hold #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          is_write,
    input  logic [DW-1:0] host_rdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (cap_en && !is_write) begin
            hold_d = host_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign rdata = hold_q;

    // R4: writes never disturb the read holding register
    a_r4_write_keeps_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        is_write |=> $stable(rdata));

endmodule

// File: rtl/hdx_dma_bridge.sv
module hdx_dma_bridge #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          host_req,
    output logic          host_we,
    output logic [AW-1:0] host_addr,
    output logic [DW-1:0] host_wdata,
    input  logic          host_ack,
    input  logic [DW-1:0] host_rdata
);

    logic load;
    logic cap_en;

    hdx_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .host_ack (host_ack),
        .load     (load),
        .cap_en   (cap_en),
        .req      (host_req),
        .busy     (busy),
        .done     (done)
    );

    hdx_cmd_regs #(.AW(AW), .DW(DW)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .cmd_we    (host_we),
        .cmd_addr  (host_addr),
        .cmd_wdata (host_wdata)
    );

    hdx_rd_hold #(.DW(DW)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .is_write   (host_we),
        .host_rdata (host_rdata),
        .rdata      (rdata)
    );

    // R2: an idle strobe issues a request carrying the presented command
    a_r2_issue: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> host_req && busy && host_addr == $past(addr)
                           && host_we == $past(wr_en));

    // R3 / R8: pending request holds command and direction
    a_r3_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && !host_ack |=> host_req && $stable(host_addr)
                                  && $stable(host_we) && $stable(host_wdata));

    // R5: request drops after acknowledge, done follows one cycle later
    a_r5_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && host_ack |=> !host_req && busy ##1 done && !busy);

    // R9: acknowledge without a request has no effect on idle state
    a_r9_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && host_ack && !start |=> !host_req && $stable(done) && $stable(rdata));

endmodule

// File: tb/hdx_dma_bridge_test.sv
module hdx_dma_bridge_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int MEMN = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          busy, done, host_req, host_we;
    logic [DW-1:0] rdata, host_wdata;
    logic [AW-1:0] host_addr;
    logic          host_ack = 1'b0;
    logic [DW-1:0] host_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [DW-1:0] mem [MEMN];
    logic [DW-1:0] exp_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdx_dma_bridge #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .busy(busy), .done(done),
        .rdata(rdata), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata)
    );

    function automatic logic [DW-1:0] seed_word(int i);
        return DW'(i * 16'h1111) ^ 16'h5A5A;
    endfunction

    function automatic int idx(logic [AW-1:0] a);
        return int'(a[3:0]);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One transfer; lat = wait cycles before ack; poke = inject a stray start
    task automatic xfer(bit we, logic [AW-1:0] a, logic [DW-1:0] d, int lat, bit poke);
        @(negedge clk);
        start = 1'b1; wr_en = we; addr = a; wdata = d;
        @(negedge clk);
        start = 1'b0; wr_en = ~we; addr = ~a; wdata = ~d;
        chk("R2 host_req", host_req, 1);
        chk("R2 busy", busy, 1);
        chk("R6 done cleared", done, 0);
        chk("R2 host_addr", host_addr, a);
        chk("R8 host_we", host_we, we);
        if (we) chk("R2 host_wdata", host_wdata, d);
        for (int k = 0; k < lat; k++) begin
            if (poke && k == 0) begin
                start = 1'b1; wr_en = ~we; addr = a ^ 16'h00F3;
            end
            @(negedge clk);
            start = 1'b0;
            chk("R3 req held", host_req, 1);
            chk("R7 addr held", host_addr, a);
            chk("R8 dir held", host_we, we);
            if (we) chk("R3 wdata held", host_wdata, d);
        end
        host_ack = 1'b1;
        host_rdata = mem[idx(a)];
        if (!we) exp_rdata = mem[idx(a)];
        else mem[idx(a)] = host_wdata;
        @(negedge clk);
        host_ack = 1'b0;
        host_rdata = 16'hDEAD;
        chk("R5 req dropped", host_req, 0);
        chk("R5 busy in finish", busy, 1);
        chk("R5 done not yet", done, 0);
        @(negedge clk);
        chk("R5 done", done, 1);
        chk("R5 busy low", busy, 0);
        chk("R7 no extra request", host_req, 0);
        chk("R4 rdata", rdata, exp_rdata);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEMN; i++) mem[i] = seed_word(i);
        exp_rdata = '0;
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 host_req", host_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        xfer(1'b0, 16'h0003, 16'h0000, 0, 1'b0);   // zero-wait read
        xfer(1'b1, 16'h0003, 16'hBEEF, 25, 1'b1);  // long write with stray strobe
        xfer(1'b0, 16'h0003, 16'h0000, 2, 1'b1);   // read back
        chk("R4 readback", rdata, 16'hBEEF);

        // R6: done persists while idle
        repeat (4) @(negedge clk);
        chk("R6 done held", done, 1);
        // R9: stray acknowledge while idle
        host_ack = 1'b1; host_rdata = 16'h1234;
        @(negedge clk);
        host_ack = 1'b0;
        @(negedge clk);
        chk("R9 no request", host_req, 0);
        chk("R9 done kept", done, 1);
        chk("R9 rdata kept", rdata, 16'hBEEF);

        // constrained random mix
        for (int n = 0; n < 60; n++) begin
            xfer(1'($urandom_range(0, 1)), AW'($urandom_range(0, MEMN - 1)),
                 DW'($urandom), int'($urandom_range(0, 9)),
                 1'($urandom_range(0, 1)));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule